// File: doc/BRIEF.md
# Triggered Hit Frame Recorder

The block captures hit patterns from a 64-channel digital detector front end. Each channel presents a 2-bit discriminator code every clock. A bunch-crossing counter advances once per clock. In any crossing where at least one code is nonzero, the block stores one frame in on-chip memory. A frame holds an identifier byte, the crossing number and the codes of all channels.

Storage stops at a fixed depth. Until then, the stored frames are counted on `frame_count`. On request, the frames are sent out one bit per clock on a serial line. The last frame stored goes out first. An acquisition start clears the counter and the memory count. A readout request ends the acquisition. A new start is then needed before further hits are stored.

Top module: `hit_frame_recorder`

## Requirements
- R1: After synchronous reset, `frame_count` is 0, `mem_full` is 0, `sout_valid` is 0 and the block is not acquiring.
- R2: The crossing counter is BX_W bits wide (default 24). It is cleared by an accepted `acq_start`, increments on every clock and wraps modulo 2^BX_W. The value stored in a frame is the counter value in the clock of the write.
- R3: While acquiring, a clock with any nonzero channel code writes exactly one frame and increments `frame_count` by one. A clock with all codes zero writes nothing.
- R4: A frame is FRAME_W = HDR_W+BX_W+NCH*CODE_W bits, sent most significant bit first. The bits go out as `chip_id` (sampled at the write), then the crossing number, then `hit_codes`. Channel i sits at `hit_codes[2i+1:2i]`, so channel 63 goes out first.
- R5: `mem_full` is high exactly when `frame_count` equals DEPTH (default 128). While it is high, hits are ignored and the stored frames are unchanged.
- R6: An accepted `readout_req` with frames stored ends acquisition. `sout_valid` then stays high for `frame_count`×FRAME_W consecutive clocks, and the frames go out newest first. `frame_count` drops by one after each frame's last bit. The block is idle at the end and ignores hits until the next `acq_start`.
- R7: A `readout_req` with no frames stored produces no serial output and ends acquisition.
- R8: While a readout is running, `acq_start` and `readout_req` are ignored. `readout_req` takes priority over `acq_start` in the same clock. An accepted `acq_start` takes priority over a hit in the same clock: no frame is written and the count is 0.
- R9: Hits arriving while the block is not acquiring are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one crossing and one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Begin acquisition: clears crossing counter and frame count |
| readout_req | input | 1 | End acquisition and unload stored frames |
| hit_codes | input | 128 | 2-bit code per channel, channel i at bits [2i+1:2i] |
| chip_id | input | 8 | Static identifier placed in each frame header |
| mem_full | output | 1 | Memory holds DEPTH frames |
| frame_count | output | 8 | Number of frames currently stored |
| sout_valid | output | 1 | Serial bit on `sout_data` is part of a frame |
| sout_data | output | 1 | Serial frame data, MSB first |

## Verification
The bench drives the crossing counter past its wrap point before filling the memory. A counter that saturated or was the wrong width would show up as wrong crossing numbers in the serialized frames. It keeps hitting after the 128th frame. A design with an off-by-one on the full test would store a 129th frame or stop at 127, and the readout length would then be wrong. Start and readout requests are asserted during an unload and together in one clock, and a start is made to coincide with a hit. A wrong priority would restart the count mid-stream or record a stale frame. A readout of an empty memory must produce no valid bits at all.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

    localparam int DEF_NCH    = 64;
    localparam int DEF_CODE_W = 2;
    localparam int DEF_BX_W   = 24;
    localparam int DEF_HDR_W  = 8;
    localparam int DEF_DEPTH  = 128;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_READ = 2'd2
    } rec_state_t;

    function automatic int frame_bits(input int hdr_w, input int bx_w,
                                      input int nch, input int code_w);
        return hdr_w + bx_w + nch * code_w;
    endfunction

endpackage

// File: rtl/hfr_bx_counter.sv
module hfr_bx_counter #(
    parameter int BX_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    output logic [BX_W-1:0] bx
);
    always_ff @(posedge clk) begin
        if (rst || clear) bx <= '0;
        else              bx <= bx + 1'b1;
    end
endmodule

// File: rtl/hfr_frame_ram.sv
module hfr_frame_ram #(
    parameter int WIDTH = 160,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/hfr_shifter.sv
module hfr_shifter #(
    parameter int WIDTH = 160,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] frame,
    output logic             msb,
    output logic             last
);
    logic [WIDTH-1:0] sreg;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= frame;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[WIDTH-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign msb  = sreg[WIDTH-1];
    assign last = (idx == IW'(WIDTH - 1));
endmodule

// File: rtl/hit_frame_recorder.sv
module hit_frame_recorder
    import hfr_pkg::*;
#(
    parameter int NCH    = DEF_NCH,
    parameter int CODE_W = DEF_CODE_W,
    parameter int BX_W   = DEF_BX_W,
    parameter int HDR_W  = DEF_HDR_W,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acq_start,
    input  logic                       readout_req,
    input  logic [NCH*CODE_W-1:0]      hit_codes,
    input  logic [HDR_W-1:0]           chip_id,
    output logic                       mem_full,
    output logic [$clog2(DEPTH+1)-1:0] frame_count,
    output logic                       sout_valid,
    output logic                       sout_data
);
    localparam int HIT_W   = NCH * CODE_W;
    localparam int FRAME_W = frame_bits(HDR_W, BX_W, NCH, CODE_W);
    localparam int AW      = $clog2(DEPTH);
    localparam int CW      = $clog2(DEPTH + 1);

    rec_state_t         state;
    logic [CW-1:0]      count;
    logic [BX_W-1:0]    bx;
    logic [FRAME_W-1:0] wr_frame, rd_frame;
    logic [CW-1:0]      rd_sel;
    logic               take_read, take_start, wr_en, any_hit;
    logic               sh_load, sh_last, at_depth;

    assign any_hit    = |hit_codes;
    assign at_depth   = (count == CW'(DEPTH));
    assign take_read  = readout_req && (state != ST_READ);
    assign take_start = acq_start && (state != ST_READ) && !readout_req;
    assign wr_en      = (state == ST_ACQ) && !take_read && !acq_start
                        && any_hit && !at_depth;
    assign wr_frame   = {chip_id, bx, hit_codes};

    // Newest frame first: entering readout fetches count-1, each later reload fetches count-2
    assign rd_sel  = count - ((state == ST_READ) ? CW'(2) : CW'(1));
    assign sh_load = (take_read && count != '0)
                     || (state == ST_READ && sh_last && count != CW'(1));

    hfr_bx_counter #(.BX_W(BX_W)) u_bx (
        .clk   (clk),
        .rst   (rst),
        .clear (take_start),
        .bx    (bx)
    );

    hfr_frame_ram #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (count[AW-1:0]),
        .wdata (wr_frame),
        .raddr (rd_sel[AW-1:0]),
        .rdata (rd_frame)
    );

    hfr_shifter #(.WIDTH(FRAME_W)) u_sh (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .shift (state == ST_READ),
        .frame (rd_frame),
        .msb   (sout_data),
        .last  (sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            count <= '0;
        end else if (take_read) begin
            state <= (count != '0) ? ST_READ : ST_IDLE;
        end else if (state == ST_READ) begin
            if (sh_last) begin
                count <= count - 1'b1;
                if (count == CW'(1)) state <= ST_IDLE;
            end
        end else if (take_start) begin
            state <= ST_ACQ;
            count <= '0;
        end else if (wr_en) begin
            count <= count + 1'b1;
        end
    end

    assign mem_full    = at_depth;
    assign frame_count = count;
    assign sout_valid  = (state == ST_READ);

endmodule

// File: rtl/hfr_checker.sv
module hfr_checker #(
    parameter int HIT_W = 128,
    parameter int DEPTH = 128,
    parameter int CW    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             acq_start,
    input logic             readout_req,
    input logic [HIT_W-1:0] hit_codes,
    input logic [CW-1:0]    frame_count,
    input logic             mem_full,
    input logic             sout_valid
);
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        frame_count <= CW'(DEPTH));

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
        mem_full && !sout_valid && !readout_req && !acq_start |=> mem_full);

    assert_quiet_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (hit_codes == '0) && !sout_valid && !acq_start && !readout_req
        |=> $stable(frame_count));

    assert_single_write_R3: assert property (@(posedge clk) disable iff (rst)
        !sout_valid && !acq_start && !readout_req
        |=> (frame_count == $past(frame_count)) || (frame_count == $past(frame_count) + 1'b1));

    assert_drain_down_R6: assert property (@(posedge clk) disable iff (rst)
        sout_valid |=> frame_count <= $past(frame_count));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        readout_req && !sout_valid && frame_count == '0 |=> !sout_valid);

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        acq_start && !readout_req && !sout_valid |=> frame_count == '0 && !mem_full);
endmodule

bind hit_frame_recorder hfr_checker #(
    .HIT_W (NCH * CODE_W),
    .DEPTH (DEPTH),
    .CW    ($clog2(DEPTH + 1))
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acq_start   (acq_start),
    .readout_req (readout_req),
    .hit_codes   (hit_codes),
    .frame_count (frame_count),
    .mem_full    (mem_full),
    .sout_valid  (sout_valid)
);

// File: tb/hit_frame_recorder_test.sv
module hit_frame_recorder_test;
    localparam int NCH     = 64;
    localparam int CODE_W  = 2;
    localparam int BX_W    = 12;
    localparam int HDR_W   = 8;
    localparam int DEPTH   = 128;
    localparam int HIT_W   = NCH * CODE_W;
    localparam int FRAME_W = HDR_W + BX_W + HIT_W;
    localparam int CW      = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acq_start = 1'b0, readout_req = 1'b0;
    logic [HIT_W-1:0] hit_codes = '0;
    logic [HDR_W-1:0] chip_id = 8'hA5;
    logic mem_full, sout_valid, sout_data;
    logic [CW-1:0] frame_count;

    always #10 clk = ~clk;

    hit_frame_recorder #(.NCH(NCH), .CODE_W(CODE_W), .BX_W(BX_W),
                         .HDR_W(HDR_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .acq_start(acq_start), .readout_req(readout_req),
        .hit_codes(hit_codes), .chip_id(chip_id), .mem_full(mem_full),
        .frame_count(frame_count), .sout_valid(sout_valid), .sout_data(sout_data)
    );

    int checks = 0, errors = 0, cycles = 0;
    string tag = "R1";

    // bench reference state
    int mstate = 0, mcount = 0, mbit = 0;
    logic [BX_W-1:0] mbx = '0;
    logic [FRAME_W-1:0] mmem [DEPTH];

    function automatic logic [HIT_W-1:0] rand_hits();
        logic [HIT_W-1:0] v;
        for (int i = 0; i < HIT_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [HIT_W-1:0] one_channel();
        logic [HIT_W-1:0] v = '0;
        int ch = $urandom % NCH;
        v[ch*2 +: 2] = 2'($urandom % 3 + 1);
        return v;
    endfunction

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic a, input logic r, input logic [HIT_W-1:0] h);
        bit taker, takes, wr;
        logic [BX_W-1:0] nbx;
        taker = r && mstate != 2;
        takes = a && mstate != 2 && !r;
        wr    = mstate == 1 && !taker && !a && h != '0 && mcount != DEPTH;
        if (wr) mmem[mcount] = {chip_id, mbx, h};
        nbx = takes ? '0 : mbx + 1'b1;
        if (rst) begin
            mstate = 0; mcount = 0; mbit = 0; nbx = '0;
        end else if (taker) begin
            mstate = (mcount != 0) ? 2 : 0; mbit = 0;
        end else if (mstate == 2) begin
            if (mbit == FRAME_W - 1) begin
                mcount--; mbit = 0;
                if (mcount == 0) mstate = 0;
            end else mbit++;
        end else if (takes) begin
            mstate = 1; mcount = 0;
        end else if (wr) mcount++;
        mbx = nbx;
    endtask

    task automatic step(input logic a, input logic r, input logic [HIT_W-1:0] h);
        acq_start = a; readout_req = r; hit_codes = h;
        model_edge(a, r, h);
        @(posedge clk);
        @(negedge clk);
        check("frame_count", frame_count, mcount);
        check("mem_full", mem_full, mcount == DEPTH);
        check("sout_valid", sout_valid, mstate == 2);
        if (mstate == 2)
            check("sout_data", sout_data, mmem[mcount-1][FRAME_W-1-mbit]);
    endtask

    task automatic drain(input bit noisy);
        int guard = 0;
        while (mstate == 2 && guard < 40000) begin
            if (noisy) step(($urandom % 7) == 0, ($urandom % 5) == 0,
                            (($urandom % 3) == 0) ? rand_hits() : '0);
            else step(1'b0, 1'b0, '0);
            guard++;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        tag = "R1";
        step(1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0);
        rst = 1'b0;
        step(1'b0, 1'b0, '0);

        tag = "R9";  // hits before any acquisition
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, rand_hits());

        tag = "R3";  // random sparse hits
        step(1'b1, 1'b0, '0);
        for (int i = 0; i < 300; i++) begin
            int k = $urandom % 8;
            step(1'b0, 1'b0, (k == 0) ? rand_hits() : (k == 1) ? one_channel() : '0);
        end

        tag = "R8";  // start coinciding with a hit
        step(1'b1, 1'b0, rand_hits());
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, (($urandom % 2) == 0) ? one_channel() : '0);

        tag = "R4";  // readout with requests and hits injected mid-stream
        step(1'b0, 1'b1, rand_hits());
        drain(1'b1);

        tag = "R6";  // hits after readout stay unrecorded
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, rand_hits());

        tag = "R7";  // empty readout
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b1, '0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, rand_hits());

        tag = "R8";  // readout and start in the same clock
        chip_id = 8'h3C;
        step(1'b1, 1'b0, '0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, one_channel());
        step(1'b1, 1'b1, rand_hits());
        drain(1'b1);

        tag = "R2";  // run the crossing counter through its wrap, then fill
        step(1'b1, 1'b0, '0);
        for (int i = 0; i < (1 << BX_W) - 60; i++) step(1'b0, 1'b0, '0);
        tag = "R5";
        for (int i = 0; i < DEPTH + 40; i++) step(1'b0, 1'b0, one_channel());
        tag = "R2";
        step(1'b0, 1'b1, '0);
        drain(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule